// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block lets a scheduler hoist a load above earlier stores whose addresses are not yet known to differ. When the hoisted load runs, it records its destination register tag and its memory address in a small table. Every store that executes later broadcasts its address, and any recorded load whose address lands in the same 8-byte granule is struck out. When the program reaches the load's original position, a check names the register tag. The check passes only if a live record for that tag is still present. A fail sends software to its recovery path.

The table is searched fully associatively by address for stores and by tag for loads and checks. A load to a tag that already has a record reuses that record. Otherwise the load takes the lowest-numbered empty slot. When there is no empty slot, a rotating victim is displaced. Losing a record this way can only turn a later pass into a fail, so it is always safe. Check answers are combinational from the current contents. Every table update lands at the next rising clock edge.

Top module: `spec_load_check_table`

## Requirements
- R1: A load recorded in one cycle makes a check for the same tag in any later cycle report pass, provided no matching store, no displacement and no earlier check for that tag has come in between.
- R2: A store clears every live record whose address agrees with the store address in bits 31 down to 3. Addresses that differ only in bits 2 down to 0 count as a match, and addresses that differ in any higher bit do not.
- R3: A check for a tag whose record was cleared by a store reports fail.
- R4: A check for a tag with no live record reports fail. While the check request is high, exactly one of pass and fail is high. While it is low, both are low, including right after reset.
- R5: Any check, whether it passes or fails, leaves no live record for its tag, so an immediate second check for that tag reports fail.
- R6: A load to a tag that already has a live record replaces that record's address in place. Each tag has at most one live record, so a store to the replaced address no longer affects the tag.
- R7: While empty slots remain, a load to a new tag takes one of them, so eight loads to distinct tags into an empty table all survive.
- R8: With all eight slots live, a load to a new tag displaces a victim chosen by a pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each displacement. Slots fill lowest-first, so the displaced tag is the oldest one filled, and its check fails.
- R9: When a load and a store to the same granule arrive in the same cycle, the load counts as younger: its new record survives, and other matching records are cleared.
- R10: A check in the same cycle as the load to its tag sees the table before that load and reports fail. The load is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset, empties the table |
| ldValid | input | 1 | Speculative load request |
| ldTag | input | 7 | Destination register tag of the load |
| ldAddr | input | 32 | Byte address of the load |
| stValid | input | 1 | Store broadcast request |
| stAddr | input | 32 | Byte address of the store |
| chkValid | input | 1 | Check request |
| chkTag | input | 7 | Register tag being checked |
| chkPass | output | 1 | Live record found for the checked tag |
| chkFail | output | 1 | No live record for the checked tag |

## Verification
The hardest state to reach from the ports is a full table whose victim pointer has already moved. Reaching it needs eight distinct live tags with no intervening check or matching store. The stimulus first sweeps checks over all 128 tags so the table is known to be empty. It then loads eight fresh tags and follows with two more, so the first two slots are displaced in order. Same-cycle collisions (store with load, check with load) are driven as directed cases. A random phase over a small tag and granule pool then mixes all three request kinds against a behavioural model.

// File: rtl/slct_pkg.sv
package slct_pkg;
  localparam int DEF_ENTRIES  = 8;
  localparam int DEF_TAG_W    = 7;
  localparam int DEF_ADDR_W   = 32;
  localparam int DEF_GRAN_LSB = 3;

  // Strobes from control to the entry store
  typedef struct packed {
    logic wrEn;       // write the one-hot selected entry
    logic stKillEn;   // clear entries matching the store granule
    logic chkKillEn;  // clear the entry matching the checked tag
  } tblCtl_t;
endpackage

// File: rtl/slct_entries.sv
module slct_entries
  import slct_pkg::*;
#(
  parameter int ENTRIES  = DEF_ENTRIES,
  parameter int TAG_W    = DEF_TAG_W,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int GRAN_LSB = DEF_GRAN_LSB
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblCtl_t            ctl,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic [TAG_W-1:0]   ldTag,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [TAG_W-1:0]   chkTag,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] ldHitVec,
  output logic [ENTRIES-1:0] chkHitVec,
  output logic [ENTRIES-1:0] stHitVec
);
  localparam int GRAN_W = ADDR_W - GRAN_LSB;

  logic [GRAN_W-1:0] ldGran;
  logic [GRAN_W-1:0] stGran;
  logic              unusedLow;

  assign ldGran    = ldAddr[ADDR_W-1:GRAN_LSB];
  assign stGran    = stAddr[ADDR_W-1:GRAN_LSB];
  assign unusedLow = ^{ldAddr[GRAN_LSB-1:0], stAddr[GRAN_LSB-1:0]};

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic              validQ;
    logic [TAG_W-1:0]  tagQ;
    logic [GRAN_W-1:0] granQ;
    logic              killNow;

    assign validVec[i]  = validQ;
    assign ldHitVec[i]  = validQ && (tagQ == ldTag);
    assign chkHitVec[i] = validQ && (tagQ == chkTag);
    assign stHitVec[i]  = validQ && (granQ == stGran);
    assign killNow      = (ctl.stKillEn && stHitVec[i]) ||
                          (ctl.chkKillEn && chkHitVec[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        tagQ   <= '0;
        granQ  <= '0;
      end else if (ctl.wrEn && wrSel[i]) begin
        validQ <= 1'b1;
        tagQ   <= ldTag;
        granQ  <= ldGran;
      end else if (killNow) begin
        validQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slct_ctl.sv
module slct_ctl
  import slct_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic               stValid,
  input  logic               chkValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] ldHitVec,
  input  logic [ENTRIES-1:0] chkHitVec,
  output tblCtl_t            ctl,
  output logic [ENTRIES-1:0] wrSel,
  output logic               chkPass,
  output logic               chkFail
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [ENTRIES-1:0] ONE_VEC  = ENTRIES'(1);

  logic [IDX_W-1:0]   rrPtr;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] freeLow;
  logic [ENTRIES-1:0] victimSel;
  logic               tagHit;
  logic               anyFree;
  logic               doReplace;

  assign freeVec   = ~validVec;
  assign freeLow   = freeVec & (~freeVec + ONE_VEC);
  assign victimSel = ONE_VEC << rrPtr;
  assign tagHit    = |ldHitVec;
  assign anyFree   = |freeVec;
  assign doReplace = ldValid && !tagHit && !anyFree;

  always_comb begin
    if (tagHit)       wrSel = ldHitVec;
    else if (anyFree) wrSel = freeLow;
    else              wrSel = victimSel;
  end

  assign ctl.wrEn      = ldValid;
  assign ctl.stKillEn  = stValid;
  assign ctl.chkKillEn = chkValid;

  assign chkPass = chkValid && (|chkHitVec);
  assign chkFail = chkValid && !(|chkHitVec);

  always_ff @(posedge clk) begin
    if (!rstN)          rrPtr <= '0;
    else if (doReplace) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/spec_load_check_table.sv
module spec_load_check_table
  import slct_pkg::*;
#(
  parameter int ENTRIES  = DEF_ENTRIES,
  parameter int TAG_W    = DEF_TAG_W,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int GRAN_LSB = DEF_GRAN_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [TAG_W-1:0]  ldTag,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              chkValid,
  input  logic [TAG_W-1:0]  chkTag,
  output logic              chkPass,
  output logic              chkFail
);
  tblCtl_t            ctl;
  logic [ENTRIES-1:0] wrSel;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] ldHitVec;
  logic [ENTRIES-1:0] chkHitVec;
  logic [ENTRIES-1:0] stHitVec;

  slct_ctl #(.ENTRIES(ENTRIES)) uCtl (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .stValid(stValid), .chkValid(chkValid),
    .validVec(validVec), .ldHitVec(ldHitVec), .chkHitVec(chkHitVec),
    .ctl(ctl), .wrSel(wrSel), .chkPass(chkPass), .chkFail(chkFail)
  );

  slct_entries #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
  ) uEntries (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrSel(wrSel),
    .ldTag(ldTag), .ldAddr(ldAddr), .stAddr(stAddr), .chkTag(chkTag),
    .validVec(validVec), .ldHitVec(ldHitVec),
    .chkHitVec(chkHitVec), .stHitVec(stHitVec)
  );
endmodule

// File: rtl/slct_chk.sv
module slct_chk #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               ldValid,
  input logic [TAG_W-1:0]   ldTag,
  input logic               stValid,
  input logic               chkValid,
  input logic [TAG_W-1:0]   chkTag,
  input logic               chkPass,
  input logic               chkFail,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] ldHitVec,
  input logic [ENTRIES-1:0] chkHitVec,
  input logic [ENTRIES-1:0] stHitVec,
  input logic [ENTRIES-1:0] wrSel
);
  logic armed;
  always_ff @(posedge clk) armed <= rstN;

  assert_chk_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> ($countones({chkPass, chkFail}) == 1));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> (!chkPass && !chkFail));

  assert_insert_visible_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(ldValid) && chkValid && chkTag == $past(ldTag)) |-> chkPass);

  assert_store_kill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stValid)) |->
      ((validVec & $past(stHitVec & ~(wrSel & {ENTRIES{ldValid}}))) == '0));

  assert_check_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(chkValid) && !$past(ldValid && ldTag == chkTag) &&
     chkValid && chkTag == $past(chkTag)) |-> chkFail);

  assert_tag_unique_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(chkHitVec) <= 1) && ($countones(ldHitVec) <= 1));

  assert_load_survives_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(ldValid)) |-> ((validVec & $past(wrSel)) != '0));
endmodule

bind spec_load_check_table slct_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) uChk (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldTag(ldTag),
  .stValid(stValid), .chkValid(chkValid), .chkTag(chkTag),
  .chkPass(chkPass), .chkFail(chkFail), .validVec(validVec),
  .ldHitVec(ldHitVec), .chkHitVec(chkHitVec), .stHitVec(stHitVec),
  .wrSel(wrSel)
);

// File: tb/tb_spec_load_check_table.sv
module tb_spec_load_check_table;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ldValid, stValid, chkValid;
  logic [6:0]  ldTag, chkTag;
  logic [31:0] ldAddr, stAddr;
  logic        chkPass, chkFail;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural model state
  bit          mVal[8];
  logic [6:0]  mTag[8];
  logic [28:0] mGran[8];
  int          mPtr;

  always #5 clk = ~clk;

  spec_load_check_table dut (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldTag(ldTag), .ldAddr(ldAddr),
    .stValid(stValid), .stAddr(stAddr), .chkValid(chkValid), .chkTag(chkTag),
    .chkPass(chkPass), .chkFail(chkFail)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  function automatic bit modelHas(logic [6:0] t);
    for (int i = 0; i < 8; i++) if (mVal[i] && mTag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelUpdate();
    bit kill[8];
    int idx;
    for (int i = 0; i < 8; i++)
      kill[i] = mVal[i] && ((stValid && mGran[i] == stAddr[31:3]) ||
                            (chkValid && mTag[i] == chkTag));
    idx = -1;
    if (ldValid) begin
      for (int i = 0; i < 8; i++) if (mVal[i] && mTag[i] == ldTag) idx = i;
      if (idx < 0) for (int i = 7; i >= 0; i--) if (!mVal[i]) idx = i;
      if (idx < 0) begin
        idx = mPtr;
        mPtr = (mPtr + 1) % 8;
      end
    end
    for (int i = 0; i < 8; i++) if (kill[i]) mVal[i] = 1'b0;
    if (idx >= 0) begin
      mVal[idx]  = 1'b1;
      mTag[idx]  = ldTag;
      mGran[idx] = ldAddr[31:3];
    end
  endtask

  // drive one cycle at the falling edge, compare, advance the model
  task automatic step(string req, bit ld, logic [6:0] lt, logic [31:0] la,
                      bit st, logic [31:0] sa, bit ck, logic [6:0] ct);
    bit expPass, expFail;
    ldValid = ld; ldTag = lt; ldAddr = la;
    stValid = st; stAddr = sa;
    chkValid = ck; chkTag = ct;
    #1;
    expPass = ck && modelHas(ct);
    expFail = ck && !modelHas(ct);
    checks++;
    if (chkPass !== expPass || chkFail !== expFail) begin
      errors++;
      $display("FAIL %s: actual pass=%b fail=%b expected pass=%b fail=%b (tag %0d)",
               req, chkPass, chkFail, expPass, expFail, ct);
    end
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic doLoad(string req, logic [6:0] t, logic [31:0] a);
    step(req, 1'b1, t, a, 1'b0, 32'h0, 1'b0, 7'd0);
  endtask
  task automatic doStore(string req, logic [31:0] a);
    step(req, 1'b0, 7'd0, 32'h0, 1'b1, a, 1'b0, 7'd0);
  endtask
  task automatic doCheck(string req, logic [6:0] t);
    step(req, 1'b0, 7'd0, 32'h0, 1'b0, 32'h0, 1'b1, t);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mVal[i] = 0; mTag[i] = 0; mGran[i] = 0; end
    mPtr = 0;
    rstN = 1'b0; ldValid = 0; stValid = 0; chkValid = 0;
    ldTag = 0; chkTag = 0; ldAddr = 0; stAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state: idle outputs low, unknown tag fails
    step("R4", 0, 0, 0, 0, 0, 0, 0);
    doCheck("R4", 7'd5);

    // R1 basic insert then pass
    doLoad("R1", 7'd10, 32'h100);
    doCheck("R1", 7'd10);
    // R10 same-cycle load and check
    step("R10", 1, 7'd11, 32'h180, 0, 0, 1, 7'd11);
    doCheck("R10", 7'd11);

    // R2 / R3 granule matching
    doLoad("R3", 7'd20, 32'h200);
    doStore("R3", 32'h204);
    doCheck("R3", 7'd20);
    doLoad("R2", 7'd21, 32'h300);
    doStore("R2", 32'h308);
    doCheck("R2", 7'd21);
    doLoad("R2", 7'd22, 32'h400);
    doStore("R2", 32'h407);
    doCheck("R2", 7'd22);

    // R5 check clears
    doLoad("R5", 7'd30, 32'h500);
    doCheck("R5", 7'd30);
    doCheck("R5", 7'd30);

    // R6 overwrite in place
    doLoad("R6", 7'd40, 32'h600);
    doLoad("R6", 7'd40, 32'h700);
    doStore("R6", 32'h600);
    doCheck("R6", 7'd40);
    doLoad("R6", 7'd41, 32'h800);
    doLoad("R6", 7'd41, 32'h900);
    doStore("R6", 32'h900);
    doCheck("R6", 7'd41);

    // R9 load younger than same-cycle store
    step("R9", 1, 7'd50, 32'hA00, 1, 32'hA00, 0, 0);
    doCheck("R9", 7'd50);
    doLoad("R9", 7'd51, 32'hB00);
    step("R9", 1, 7'd52, 32'hB00, 1, 32'hB03, 0, 0);
    doCheck("R9", 7'd51);
    doCheck("R9", 7'd52);

    // empty the table through the port
    for (int t = 0; t < 128; t++) doCheck("R5", 7'(t));

    // R7 fill, R8 displacement order
    for (int t = 0; t < 8; t++) doLoad("R7", 7'(60 + t), 32'h1000 + 32'(t) * 16);
    doLoad("R8", 7'd68, 32'h2000);
    doLoad("R8", 7'd69, 32'h2010);
    doCheck("R8", 7'd60);
    doCheck("R8", 7'd61);
    for (int t = 62; t < 68; t++) doCheck("R7", 7'(t));
    doCheck("R8", 7'd68);
    doCheck("R8", 7'd69);

    // random mix over a small tag and granule pool
    for (int n = 0; n < 600; n++) begin
      step("R4",
           ($urandom_range(0, 9) < 4), 7'($urandom_range(0, 11)),
           32'($urandom_range(0, 5) * 8 + $urandom_range(0, 7)),
           ($urandom_range(0, 9) < 3),
           32'($urandom_range(0, 5) * 8 + $urandom_range(0, 7)),
           ($urandom_range(0, 9) < 5), 7'($urandom_range(0, 11)));
    end

    finishRun();
  end
endmodule